// File: doc/BRIEF.md
# Edge/Level Interrupt Pin Servicer

This block holds the per-pin request state of an interrupt routing controller. It watches a vector of interrupt pin levels and keeps one pending bit per pin. Using each pin's mask, trigger mode and remote-IRR flag, it decides when a pin may be serviced. Accepted service attempts leave over a single request/acknowledge handshake toward the destination logic, which reports whether at least one destination took the interrupt. End-of-interrupt broadcasts arrive with a vector and a trigger mode. They release level-triggered pins whose vector matches, and re-deliver those pins that are still asserted.

Each pin has a counter of back-to-back re-deliveries caused by end-of-interrupt. When that counter reaches its limit, the pin is not re-delivered at that moment. A programmable delay is started instead. When the delay ends, every level-triggered pin that is pending and not waiting for an end-of-interrupt gets a new service attempt. Entry fields such as vector, mask and trigger mode come from an external register block. That block strobes the index of any entry it rewrites.

Top module: `pinsvc`

## Requirements
- R1: After reset there is no delivery request, and the pending, remote-IRR and edge-delivered vectors are all zero.
- R2: A falling pin level clears that pin's pending bit and causes no delivery.
- R3: A rising level on an edge-triggered pin (`ent_level` bit = 0) does three things. It sets the pending bit, clears the pin's edge-delivered bit one clock later, and requests service. Issuing the delivery sets the edge-delivered bit again.
- R4: A service attempt is dropped without a request when the pin is masked (`ent_mask` bit = 1), or when the pin is level-triggered and its remote-IRR is set.
- R5: An acknowledged delivery of a level-triggered pin (`ent_level` bit = 1) with `dlv_accepted` = 1 sets that pin's remote-IRR. With `dlv_accepted` = 0, or for an edge-triggered pin, remote-IRR stays clear.
- R6: An end-of-interrupt with `eoi_level` = 1 and `directed_eoi` = 0 acts on every level-triggered entry whose 8-bit vector equals `eoi_vector`. It clears that entry's remote-IRR. If the entry is unmasked and still pending, it is also serviced again.
- R7: An end-of-interrupt with `eoi_level` = 0, or one arriving while `directed_eoi` = 1, changes no remote-IRR and causes no delivery.
- R8: Each pin counts its consecutive end-of-interrupt re-deliveries. The re-delivery that would make the count reach LIMIT is not issued. Instead the count returns to 0 and a timer of `defer_cycles` clocks starts. When the timer expires, every level-triggered pin that is pending with remote-IRR clear is serviced.
- R9: An end-of-interrupt that matches a pin which is masked or no longer pending resets that pin's re-delivery count to 0.
- R10: A rewrite strobe for an entry has one of two effects. If the rewritten entry is level-triggered and its pin is pending, it causes a service attempt. If the entry is now edge-triggered, it clears the remote-IRR and causes no delivery.
- R11: When several pins wait for service at once, they are offered one at a time over the handshake, lowest index first.
- R12: `dlv_req`, `dlv_pin`, `dlv_vector` and `dlv_level` hold steady until `dlv_ack` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_level | input | NPINS | Interrupt pin levels, 1 = asserted |
| ent_mask | input | NPINS | Entry mask bits, 1 = masked |
| ent_level | input | NPINS | Entry trigger mode, 1 = level, 0 = edge |
| ent_vector | input | NPINS*VEC_W | Entry vectors, pin i at bits [i*VEC_W +: VEC_W] |
| ent_wr_valid | input | 1 | Strobe: an entry was rewritten |
| ent_wr_idx | input | IDX_W | Index of the rewritten entry |
| directed_eoi | input | 1 | 1 = broadcast end-of-interrupt is ignored |
| defer_cycles | input | DLY_W | Storm deferral delay in clocks (0 acts as 1) |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | input | VEC_W | Vector of the end-of-interrupt |
| eoi_level | input | 1 | Trigger mode of the end-of-interrupt, 1 = level |
| dlv_req | output | 1 | Delivery request |
| dlv_pin | output | IDX_W | Pin being delivered |
| dlv_vector | output | VEC_W | Vector of the pin being delivered |
| dlv_level | output | 1 | Trigger mode of the pin being delivered |
| dlv_ack | input | 1 | Delivery acknowledge |
| dlv_accepted | input | 1 | With ack: 1 = at least one destination accepted |
| pending | output | NPINS | Pending-request vector |
| remote_irr | output | NPINS | Remote-IRR flags |
| edge_delivered | output | NPINS | Edge-delivered flags |

## Verification
The bench runs a four-pin setup that mixes one edge pin with three level pins. Two of the level pins share a vector. Rising and falling pins, masked pins and accepted versus refused deliveries separate the R2–R5 cases. Repeated end-of-interrupts, some with the edge or directed marking, separate a real release from an ignored one. Back-to-back end-of-interrupt runs, with and without a masked or deasserted pin between them, show whether the storm counter defers on the third re-delivery and whether it restarts. Simultaneous pin rises, and one end-of-interrupt covering the shared vector, expose the order of service.

// File: rtl/pinsvc_pkg.sv
package pinsvc_pkg;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    // Width of an index into a vector of n items (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pinsvc_pick.sv
module pinsvc_pick #(
    parameter int NPINS = 8,
    localparam int IDX_W = pinsvc_pkg::idx_width(NPINS)
) (
    input  logic [NPINS-1:0] req,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        valid = |req;
        idx   = '0;
        for (int i = NPINS - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    // Chosen pin must be requesting, with no lower requester left behind.
    always_comb begin
        if (valid) begin
            AST_PICK_LOWEST: assert (req[idx] &&
                ((req & ((NPINS'(1) << idx) - NPINS'(1))) == '0)); // R11
        end
    end

endmodule

// File: rtl/pinsvc_eoi.sv
module pinsvc_eoi #(
    parameter int NPINS = 8,
    parameter int VEC_W = 8,
    parameter int LIMIT = 10000,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               eoi_valid,
    input  logic [VEC_W-1:0]   eoi_vector,
    input  logic               eoi_level,
    input  logic               directed_eoi,
    input  logic [NPINS*VEC_W-1:0] ent_vector,
    input  logic [NPINS-1:0]   ent_mask,
    input  logic [NPINS-1:0]   ent_level,
    input  logic [NPINS-1:0]   pending,
    output logic [NPINS-1:0]   rirr_clr,
    output logic [NPINS-1:0]   resvc,
    output logic               defer_go
);
    import pinsvc_pkg::*;

    logic              bcast_ok;
    logic [NPINS-1:0]  defer_vec;

    assign bcast_ok = eoi_valid && (eoi_level == TRIG_LEVEL) && !directed_eoi;
    assign defer_go = |defer_vec;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic [CNT_W-1:0] cnt_d, cnt_q;
        logic             clr_b, resvc_b, defer_b;

        always_comb begin
            cnt_d   = cnt_q;
            clr_b   = 1'b0;
            resvc_b = 1'b0;
            defer_b = 1'b0;
            if (bcast_ok && (ent_level[g] == TRIG_LEVEL) &&
                (ent_vector[g*VEC_W +: VEC_W] == eoi_vector)) begin
                clr_b = 1'b1;
                if (!ent_mask[g] && pending[g]) begin
                    if (cnt_q == CNT_W'(LIMIT - 1)) begin
                        cnt_d   = '0;
                        defer_b = 1'b1;
                    end else begin
                        cnt_d   = cnt_q + CNT_W'(1);
                        resvc_b = 1'b1;
                    end
                end else begin
                    cnt_d = '0;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign rirr_clr[g]  = clr_b;
        assign resvc[g]     = resvc_b;
        assign defer_vec[g] = defer_b;

        AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q < CNT_W'(LIMIT)); // R8
        AST_NO_RESVC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
            (eoi_valid && (directed_eoi || !eoi_level)) |-> !resvc_b && !clr_b); // R7
    end

endmodule

// File: rtl/pinsvc_defer.sv
module pinsvc_defer #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DLY_W-1:0] cycles,
    output logic             fire
);

    logic [DLY_W-1:0] tmr_d, tmr_q;

    assign fire = (tmr_q == DLY_W'(1));

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d = (cycles == '0) ? DLY_W'(1) : cycles;
        end else if (tmr_q != '0) begin
            tmr_d = tmr_q - DLY_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    AST_NO_EARLY_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q > DLY_W'(2) && !start) |=> !fire); // R8

endmodule

// File: rtl/pinsvc.sv
module pinsvc #(
    parameter int NPINS = 8,
    parameter int VEC_W = 8,
    parameter int LIMIT = 10000,
    parameter int DLY_W = 16,
    localparam int IDX_W = pinsvc_pkg::idx_width(NPINS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPINS-1:0]       pin_level,
    input  logic [NPINS-1:0]       ent_mask,
    input  logic [NPINS-1:0]       ent_level,
    input  logic [NPINS*VEC_W-1:0] ent_vector,
    input  logic                   ent_wr_valid,
    input  logic [IDX_W-1:0]       ent_wr_idx,
    input  logic                   directed_eoi,
    input  logic [DLY_W-1:0]       defer_cycles,
    input  logic                   eoi_valid,
    input  logic [VEC_W-1:0]       eoi_vector,
    input  logic                   eoi_level,
    output logic                   dlv_req,
    output logic [IDX_W-1:0]       dlv_pin,
    output logic [VEC_W-1:0]       dlv_vector,
    output logic                   dlv_level,
    input  logic                   dlv_ack,
    input  logic                   dlv_accepted,
    output logic [NPINS-1:0]       pending,
    output logic [NPINS-1:0]       remote_irr,
    output logic [NPINS-1:0]       edge_delivered
);
    import pinsvc_pkg::*;

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] cur;
        logic [NPINS-1:0] pin;
        logic [NPINS-1:0] pending;
        logic [NPINS-1:0] rirr;
        logic [NPINS-1:0] dlvd;
        logic [NPINS-1:0] svc;
    } st_t;

    st_t st_d, st_q;

    logic [NPINS-1:0] rise, fall;
    logic [NPINS-1:0] rirr_clr, resvc;
    logic             defer_go, defer_fire;
    logic             pick_valid;
    logic [IDX_W-1:0] pick_idx;

    assign rise = pin_level & ~st_q.pin;
    assign fall = ~pin_level & st_q.pin;

    pinsvc_pick #(.NPINS(NPINS)) u_pick (
        .req   (st_q.svc),
        .valid (pick_valid),
        .idx   (pick_idx)
    );

    pinsvc_eoi #(.NPINS(NPINS), .VEC_W(VEC_W), .LIMIT(LIMIT)) u_eoi (
        .clk          (clk),
        .rst_n        (rst_n),
        .eoi_valid    (eoi_valid),
        .eoi_vector   (eoi_vector),
        .eoi_level    (eoi_level),
        .directed_eoi (directed_eoi),
        .ent_vector   (ent_vector),
        .ent_mask     (ent_mask),
        .ent_level    (ent_level),
        .pending      (st_q.pending),
        .rirr_clr     (rirr_clr),
        .resvc        (resvc),
        .defer_go     (defer_go)
    );

    pinsvc_defer #(.DLY_W(DLY_W)) u_defer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (defer_go),
        .cycles (defer_cycles),
        .fire   (defer_fire)
    );

    always_comb begin
        logic [NPINS-1:0] svc_set;
        logic             refused;

        st_d    = st_q;
        svc_set = rise | resvc;

        // Pin sampling and pending vector.
        st_d.pin     = pin_level;
        st_d.pending = (st_q.pending | rise) & ~fall;
        st_d.dlvd    = st_q.dlvd & ~(rise & ~ent_level);

        // Deferred re-injection sweep.
        if (defer_fire) begin
            svc_set = svc_set | (ent_level & st_q.pending & ~st_q.rirr);
        end

        // Entry rewrite.
        if (ent_wr_valid && ent_level[ent_wr_idx] == TRIG_LEVEL &&
            st_q.pending[ent_wr_idx]) begin
            svc_set[ent_wr_idx] = 1'b1;
        end

        // Handshake completion.
        if (st_q.busy && dlv_ack) begin
            st_d.busy = 1'b0;
            if (ent_level[st_q.cur] == TRIG_LEVEL && dlv_accepted) begin
                st_d.rirr[st_q.cur] = 1'b1;
            end
        end

        // Selection of the next pin to service.
        refused = 1'b0;
        st_d.svc = st_q.svc;
        if (!st_q.busy && pick_valid) begin
            st_d.svc[pick_idx] = 1'b0;
            refused = ent_mask[pick_idx] ||
                      (ent_level[pick_idx] == TRIG_LEVEL && st_q.rirr[pick_idx]);
            if (!refused) begin
                st_d.busy = 1'b1;
                st_d.cur  = pick_idx;
                if (ent_level[pick_idx] == TRIG_EDGE) begin
                    st_d.dlvd[pick_idx] = 1'b1;
                end
            end
        end
        st_d.svc = st_d.svc | svc_set;

        // End-of-interrupt release, then edge rewrite release.
        st_d.rirr = st_d.rirr & ~rirr_clr;
        if (ent_wr_valid && ent_level[ent_wr_idx] == TRIG_EDGE) begin
            st_d.rirr[ent_wr_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dlv_req        = st_q.busy;
    assign dlv_pin        = st_q.cur;
    assign dlv_vector     = ent_vector[st_q.cur*VEC_W +: VEC_W];
    assign dlv_level      = ent_level[st_q.cur];
    assign pending        = st_q.pending;
    assign remote_irr     = st_q.rirr;
    assign edge_delivered = st_q.dlvd;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_req && !dlv_ack) |=> (dlv_req && $stable(dlv_pin))); // R12
    AST_ACK_SETS_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_req && dlv_ack && dlv_accepted && dlv_level && !eoi_valid && !ent_wr_valid)
        |=> ((remote_irr >> $past(dlv_pin)) & NPINS'(1)) != '0); // R5
    AST_NO_MASKED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dlv_req) |-> (($past(ent_mask) >> dlv_pin) & NPINS'(1)) == '0); // R4

    for (genvar g = 0; g < NPINS; g++) begin : g_chk
        AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (!pin_level[g] && st_q.pin[g]) |=> !pending[g]); // R2
    end

endmodule

// File: tb/pinsvc_bench.sv
`timescale 1ns/1ps
module pinsvc_bench;
    localparam int N  = 4;
    localparam int VW = 8;
    localparam int LM = 3;
    localparam int DW = 8;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pin_level = '0;
    logic [N-1:0]  ent_mask = '0;
    logic [N-1:0]  ent_level = 4'b1110;
    logic [N*VW-1:0] ent_vector = {8'h30, 8'h30, 8'h21, 8'h20};
    logic          ent_wr_valid = 1'b0;
    logic [IW-1:0] ent_wr_idx = '0;
    logic          directed_eoi = 1'b0;
    logic [DW-1:0] defer_cycles = 8'd20;
    logic          eoi_valid = 1'b0;
    logic [VW-1:0] eoi_vector = '0;
    logic          eoi_level = 1'b0;
    logic          dlv_req;
    logic [IW-1:0] dlv_pin;
    logic [VW-1:0] dlv_vector;
    logic          dlv_level;
    logic          dlv_ack = 1'b0;
    logic          dlv_accepted = 1'b0;
    logic [N-1:0]  pending, remote_irr, edge_delivered;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pinsvc #(.NPINS(N), .VEC_W(VW), .LIMIT(LM), .DLY_W(DW)) u_pinsvc (
        .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .ent_mask(ent_mask),
        .ent_level(ent_level), .ent_vector(ent_vector), .ent_wr_valid(ent_wr_valid),
        .ent_wr_idx(ent_wr_idx), .directed_eoi(directed_eoi), .defer_cycles(defer_cycles),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level(eoi_level),
        .dlv_req(dlv_req), .dlv_pin(dlv_pin), .dlv_vector(dlv_vector), .dlv_level(dlv_level),
        .dlv_ack(dlv_ack), .dlv_accepted(dlv_accepted), .pending(pending),
        .remote_irr(remote_irr), .edge_delivered(edge_delivered)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Waits for a request, checks pin and vector, holds it, then acknowledges.
    task automatic expect_dlv(input int pin, input bit acc, input int hold, input string tag);
        bit seen = 1'b0;
        for (int k = 0; k < 40 && !seen; k++) begin
            @(negedge clk);
            seen = dlv_req;
        end
        chk(seen, {tag, " request"}, 32'(seen), 32'd1);
        if (!seen) return;
        chk(dlv_pin == IW'(pin), {tag, " pin"}, 32'(dlv_pin), 32'(pin));
        chk(dlv_vector == ent_vector[pin*VW +: VW], {tag, " vector"},
            32'(dlv_vector), 32'(ent_vector[pin*VW +: VW]));
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(dlv_req && dlv_pin == IW'(pin), "R12 request held", 32'(dlv_pin), 32'(pin));
        end
        dlv_ack = 1'b1;
        dlv_accepted = acc;
        @(negedge clk);
        dlv_ack = 1'b0;
        dlv_accepted = 1'b0;
    endtask

    task automatic expect_none(input int cycles, input string tag);
        bit any = 1'b0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            any = any | dlv_req;
        end
        chk(!any, tag, 32'(any), 32'd0);
    endtask

    task automatic eoi(input logic [VW-1:0] v, input bit lvl, input bit dir);
        eoi_vector = v;
        eoi_level = lvl;
        directed_eoi = dir;
        eoi_valid = 1'b1;
        @(negedge clk);
        eoi_valid = 1'b0;
        directed_eoi = 1'b0;
    endtask

    task automatic wr(input int idx);
        ent_wr_idx = IW'(idx);
        ent_wr_valid = 1'b1;
        @(negedge clk);
        ent_wr_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!dlv_req, "R1 no request", 32'(dlv_req), 0);
        chk(pending == 0 && remote_irr == 0 && edge_delivered == 0, "R1 state zero",
            {20'd0, pending, remote_irr, edge_delivered}, 0);

        // R3 edge pin 0
        pin_level[0] = 1'b1;
        expect_dlv(0, 1'b1, 0, "R3 edge delivery");
        chk(edge_delivered[0], "R3 delivered bit set", 32'(edge_delivered), 1);
        chk(remote_irr[0] == 1'b0, "R5 edge leaves rirr clear", 32'(remote_irr), 0);
        chk(pending[0], "R3 pending set", 32'(pending), 1);

        // R2 fall
        pin_level[0] = 1'b0;
        @(negedge clk);
        chk(pending[0] == 1'b0, "R2 pending cleared", 32'(pending), 0);
        expect_none(8, "R2 no delivery on fall");
        pin_level[0] = 1'b1;
        @(negedge clk);
        chk(edge_delivered[0] == 1'b0, "R3 delivered bit cleared on rise", 32'(edge_delivered), 0);
        expect_dlv(0, 1'b1, 0, "R3 second edge delivery");
        chk(edge_delivered[0], "R3 delivered bit set again", 32'(edge_delivered), 1);
        pin_level[0] = 1'b0;
        @(negedge clk);

        // R4 masked level pin 1
        ent_mask[1] = 1'b1;
        pin_level[1] = 1'b1;
        expect_none(6, "R4 masked pin refused");
        chk(pending[1], "R4 masked pin pending", 32'(pending), 2);
        ent_mask[1] = 1'b0;
        wr(1);
        expect_dlv(1, 1'b1, 3, "R10 rewrite services pending level pin");
        chk(remote_irr[1], "R5 accepted level sets rirr", 32'(remote_irr), 2);
        wr(1);
        expect_none(6, "R4 level pin with rirr refused");

        // R7 ignored end-of-interrupts
        eoi(8'h21, 1'b0, 1'b0);
        expect_none(4, "R7 edge eoi no delivery");
        chk(remote_irr[1], "R7 edge eoi keeps rirr", 32'(remote_irr), 2);
        eoi(8'h21, 1'b1, 1'b1);
        expect_none(4, "R7 directed eoi no delivery");
        chk(remote_irr[1], "R7 directed eoi keeps rirr", 32'(remote_irr), 2);

        // R6 / R8 storm
        eoi(8'h21, 1'b1, 1'b0);
        chk(remote_irr[1] == 1'b0, "R6 eoi clears rirr", 32'(remote_irr), 0);
        expect_dlv(1, 1'b1, 0, "R6 redelivery 1");
        eoi(8'h21, 1'b1, 1'b0);
        expect_dlv(1, 1'b1, 0, "R8 redelivery 2");
        eoi(8'h21, 1'b1, 1'b0);
        chk(remote_irr[1] == 1'b0, "R8 eoi at limit clears rirr", 32'(remote_irr), 0);
        expect_none(10, "R8 delivery deferred at limit");
        expect_dlv(1, 1'b1, 0, "R8 deferred sweep delivers");

        // R9 counter restart
        eoi(8'h21, 1'b1, 1'b0);
        expect_dlv(1, 1'b1, 0, "R9 run a 1");
        eoi(8'h21, 1'b1, 1'b0);
        expect_dlv(1, 1'b1, 0, "R9 run a 2");
        ent_mask[1] = 1'b1;
        eoi(8'h21, 1'b1, 1'b0);
        expect_none(5, "R9 masked eoi no delivery");
        chk(remote_irr[1] == 1'b0, "R9 masked eoi clears rirr", 32'(remote_irr), 0);
        ent_mask[1] = 1'b0;
        wr(1);
        expect_dlv(1, 1'b1, 0, "R10 rewrite after unmask");
        eoi(8'h21, 1'b1, 1'b0);
        expect_dlv(1, 1'b1, 0, "R9 run b 1");
        eoi(8'h21, 1'b1, 1'b0);
        expect_dlv(1, 1'b1, 0, "R9 run b 2 not deferred");
        pin_level[1] = 1'b0;
        @(negedge clk);
        eoi(8'h21, 1'b1, 1'b0);
        expect_none(5, "R9 not pending eoi no delivery");
        chk(remote_irr[1] == 1'b0, "R9 not pending eoi clears rirr", 32'(remote_irr), 0);

        // R5 refused delivery
        pin_level[2] = 1'b1;
        expect_dlv(2, 1'b0, 0, "R5 unaccepted level");
        chk(remote_irr[2] == 1'b0, "R5 unaccepted keeps rirr clear", 32'(remote_irr), 0);
        pin_level[2] = 1'b0;
        @(negedge clk);

        // R11 order
        pin_level = 4'b1101;
        expect_dlv(0, 1'b1, 0, "R11 first pin 0");
        expect_dlv(2, 1'b1, 0, "R11 second pin 2");
        expect_dlv(3, 1'b1, 0, "R11 third pin 3");
        chk(remote_irr == 4'b1100, "R5 rirr on pins 2 and 3", 32'(remote_irr), 32'hC);

        // R6 shared vector
        eoi(8'h30, 1'b1, 1'b0);
        chk(remote_irr == 4'b0000, "R6 shared vector clears both", 32'(remote_irr), 0);
        expect_dlv(2, 1'b1, 0, "R6 shared redelivery pin 2");
        expect_dlv(3, 1'b1, 0, "R6 shared redelivery pin 3");

        // R10 rewrite to edge
        ent_level[3] = 1'b0;
        wr(3);
        chk(remote_irr == 4'b0100, "R10 edge rewrite clears rirr", 32'(remote_irr), 32'h4);
        expect_none(6, "R10 edge rewrite no delivery");

        summary();
        $finish;
    end

endmodule